// File: doc/BRIEF.md
# USB PD Transmit Token Frame Builder

This block turns one USB Power Delivery transmit request into the byte sequence that a token-driven transmit FIFO expects. A request carries a kind code, a 16-bit message header and up to seven 32-bit data objects. For the three message kinds the block produces the following bytes in order:
- four ordered-set sync tokens chosen by the kind;
- a packed-length token that gives the number of literal bytes that follow;
- the header and the data objects;
- four trailer tokens that insert the CRC, end the packet, switch the transmitter off and start transmission.

Before the first byte of every frame the block raises a one-cycle FIFO flush pulse. Two other kinds build no frame. One of them raises a one-cycle hard-reset command. The other runs a BIST burst: it holds a BIST-mode level, pulses transmit start once, and waits a fixed number of cycles before it drops BIST mode.

Requests are taken on a valid/ready handshake. `req_ready` is high only while the block is idle, so a request is accepted on a clock edge where both `req_valid` and `req_ready` are high. The output byte stream uses valid/ready with a last flag. While `out_valid` is high and `out_ready` is low, the byte and the last flag hold still. A byte is consumed on each edge where both signals are high. The CRC, the line coding and the FIFO itself sit outside this block.

Top module: `pd_tx_framer`

## Requirements
- R1: Kind codes: 0 is SOP, 1 is SOP', 2 is SOP''. The first four frame bytes are SYNC1,SYNC1,SYNC1,SYNC2 for SOP; SYNC1,SYNC1,SYNC3,SYNC3 for SOP'; and SYNC1,SYNC3,SYNC1,SYNC3 for SOP''.
- R2: The fifth byte is the PACKSYM token ORed with the literal byte count in its low 5 bits. The count is 2 + 4 × N, where N is the header field `req_header[CNT_LSB +: CNT_W]`.
- R3: The literal bytes are, in this order: header bits [7:0], header bits [15:8], then for each object from 0 to N-1 its four bytes, least significant first. Object k sits at `req_objs[32k +: 32]`.
- R4: After the literal bytes come JAMCRC, EOP, TXOFF and TXON, in that order. TXON is the only byte that carries `out_last`. A frame is 9 + 2 + 4N bytes long, at most 39.
- R5: `fifo_flush` is high for exactly the one cycle after a frame request is accepted. `out_valid` rises in the cycle after that.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. `req_ready` is low from acceptance until the cycle after the last byte has been consumed.
- R7: A message kind whose N exceeds MAX_OBJ raises `req_error` for the one cycle after acceptance. It emits no byte and raises no flush.
- R8: Kind 3 raises `hard_reset_cmd` for one cycle after acceptance, emits no byte, and then returns to idle.
- R9: Kind 4 holds `bist_mode` high for 1 + BIST_WAIT cycles. `tx_start` pulses once, in the first of those cycles.
- R10: Kind codes 5 to 7 raise `req_error` for one cycle and produce nothing else.
- R11: Out of reset, `req_ready` is high and every other output strobe and level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_kind | input | 3 | Request kind code |
| req_header | input | 16 | Message header |
| req_objs | input | 32×MAX_OBJ | Data objects, object 0 in the low word |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes byte |
| out_data | output | 8 | Token or literal byte |
| out_last | output | 1 | Final byte of the frame |
| fifo_flush | output | 1 | Transmit FIFO flush pulse |
| hard_reset_cmd | output | 1 | Send-hard-reset command pulse |
| bist_mode | output | 1 | BIST carrier mode level |
| tx_start | output | 1 | Transmit start pulse for BIST |
| req_error | output | 1 | Request rejected pulse |

## Verification
The bench builds the block with a 4-bit count field (CNT_W = 4) and BIST_WAIT = 5. The wider count field lets a header ask for eight or more objects, so the reject path of R7 can be reached at all; with the default 3-bit field it cannot. The short BIST wait keeps the whole burst of R9 within a few cycles, so the bench can count its length exactly. The frame vectors cover all three sync patterns, object counts from 0 to 7, and both a free-running and a stalling consumer, so every byte is also checked while it is held.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

  typedef enum logic [2:0] {
    KIND_SOP    = 3'd0,
    KIND_SOP_P  = 3'd1,
    KIND_SOP_PP = 3'd2,
    KIND_HRST   = 3'd3,
    KIND_BIST   = 3'd4
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_EMIT,
    ST_HRST,
    ST_BSTART,
    ST_BHOLD,
    ST_ERR
  } fsm_state_e;

endpackage

// File: rtl/pd_tx_len_calc.sv
module pd_tx_len_calc
  import pd_tx_pkg::*;
#(
  parameter int MAX_OBJ = 7,
  parameter int CNT_LSB = 12,
  parameter int CNT_W   = 3,
  parameter int LEN_W   = 6
) (
  input  logic [15:0]      hdr,
  input  logic [2:0]       kind,
  output logic [LEN_W-1:0] pay_len,
  output logic [LEN_W-1:0] frame_len,
  output logic             is_frame,
  output logic             is_hrst,
  output logic             is_bist,
  output logic             is_bad
);

  logic [CNT_W-1:0] obj_cnt;
  logic [LEN_W-1:0] cnt_ext;
  logic             cnt_over;

  always_comb begin
    obj_cnt   = hdr[CNT_LSB +: CNT_W];
    cnt_ext   = LEN_W'(obj_cnt);
    pay_len   = LEN_W'(2) + (cnt_ext << 2);
    frame_len = pay_len + LEN_W'(9);
    cnt_over  = cnt_ext > LEN_W'(MAX_OBJ);
    is_frame  = (kind == KIND_SOP) || (kind == KIND_SOP_P) || (kind == KIND_SOP_PP);
    is_hrst   = (kind == KIND_HRST);
    is_bist   = (kind == KIND_BIST);
    is_bad    = (is_frame && cnt_over) || !(is_frame || is_hrst || is_bist);
  end

endmodule

// File: rtl/pd_tx_byte_sel.sv
module pd_tx_byte_sel
  import pd_tx_pkg::*;
#(
  parameter int         MAX_OBJ  = 7,
  parameter int         LEN_W    = 6,
  parameter logic [7:0] T_SYNC1  = 8'h12,
  parameter logic [7:0] T_SYNC2  = 8'h13,
  parameter logic [7:0] T_SYNC3  = 8'h1B,
  parameter logic [7:0] T_PACK   = 8'h80,
  parameter logic [7:0] T_JAMCRC = 8'hFF,
  parameter logic [7:0] T_EOP    = 8'h14,
  parameter logic [7:0] T_TXOFF  = 8'hFE,
  parameter logic [7:0] T_TXON   = 8'hA1
) (
  input  logic [2:0]            kind,
  input  logic [15:0]           hdr,
  input  logic [MAX_OBJ*32-1:0] objs,
  input  logic [LEN_W-1:0]      pay_len,
  input  logic [LEN_W-1:0]      idx,
  output logic [7:0]            byte_o
);

  localparam int NBYTES = MAX_OBJ * 4;

  logic [7:0] obj_byte [NBYTES];

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_split
      assign obj_byte[g] = objs[g*8 +: 8];
    end
  endgenerate

  function automatic logic [7:0] sync_tok(input logic [2:0] k, input logic [LEN_W-1:0] pos);
    logic [7:0] t;
    t = T_SYNC1;
    case (k)
      KIND_SOP_P:  if (pos >= LEN_W'(2)) t = T_SYNC3;
      KIND_SOP_PP: if (pos[0]) t = T_SYNC3;
      default:     if (pos == LEN_W'(3)) t = T_SYNC2;
    endcase
    return t;
  endfunction

  logic [LEN_W-1:0] lit_pos;
  logic [LEN_W-1:0] tail_pos;
  logic [7:0]       lit_byte;

  always_comb begin
    lit_pos  = idx - LEN_W'(5);
    tail_pos = lit_pos - pay_len;
    lit_byte = 8'h00;
    if (lit_pos == LEN_W'(0)) lit_byte = hdr[7:0];
    else if (lit_pos == LEN_W'(1)) lit_byte = hdr[15:8];
    for (int b = 0; b < NBYTES; b++) begin
      if (lit_pos == LEN_W'(b + 2)) lit_byte = obj_byte[b];
    end
  end

  always_comb begin
    if (idx < LEN_W'(4)) begin
      byte_o = sync_tok(kind, idx);
    end else if (idx == LEN_W'(4)) begin
      byte_o = T_PACK | {3'b000, pay_len[4:0]};
    end else if (lit_pos < pay_len) begin
      byte_o = lit_byte;
    end else begin
      case (tail_pos)
        LEN_W'(0): byte_o = T_JAMCRC;
        LEN_W'(1): byte_o = T_EOP;
        LEN_W'(2): byte_o = T_TXOFF;
        default:   byte_o = T_TXON;
      endcase
    end
  end

endmodule

// File: rtl/pd_tx_ctrl.sv
module pd_tx_ctrl
  import pd_tx_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int BIST_WAIT = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             is_frame,
  input  logic             is_hrst,
  input  logic             is_bad,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             out_ready,
  output logic             req_ready,
  output logic [LEN_W-1:0] idx,
  output logic             out_valid,
  output logic             out_last,
  output logic             fifo_flush,
  output logic             hard_reset_cmd,
  output logic             bist_mode,
  output logic             tx_start,
  output logic             req_error
);

  localparam int BW = $clog2(BIST_WAIT + 1);

  fsm_state_e       state;
  logic [LEN_W-1:0] last_q;
  logic [BW-1:0]    bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      last_q <= '0;
      bcnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (is_bad) begin
              state <= ST_ERR;
            end else if (is_frame) begin
              state  <= ST_FLUSH;
              last_q <= frame_len - LEN_W'(1);
            end else if (is_hrst) begin
              state <= ST_HRST;
            end else begin
              state <= ST_BSTART;
            end
          end
        end
        ST_FLUSH: begin
          state <= ST_EMIT;
          idx   <= '0;
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (idx == last_q) state <= ST_IDLE;
            else idx <= idx + LEN_W'(1);
          end
        end
        ST_BSTART: begin
          state <= ST_BHOLD;
          bcnt  <= BW'(BIST_WAIT - 1);
        end
        ST_BHOLD: begin
          if (bcnt == '0) state <= ST_IDLE;
          else bcnt <= bcnt - BW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready      = (state == ST_IDLE);
    out_valid      = (state == ST_EMIT);
    out_last       = (state == ST_EMIT) && (idx == last_q);
    fifo_flush     = (state == ST_FLUSH);
    hard_reset_cmd = (state == ST_HRST);
    tx_start       = (state == ST_BSTART);
    bist_mode      = (state == ST_BSTART) || (state == ST_BHOLD);
    req_error      = (state == ST_ERR);
  end

endmodule

// File: rtl/pd_tx_framer.sv
module pd_tx_framer
  import pd_tx_pkg::*;
#(
  parameter int         MAX_OBJ   = 7,
  parameter int         CNT_LSB   = 12,
  parameter int         CNT_W     = 3,
  parameter int         BIST_WAIT = 2000,
  parameter logic [7:0] T_SYNC1   = 8'h12,
  parameter logic [7:0] T_SYNC2   = 8'h13,
  parameter logic [7:0] T_SYNC3   = 8'h1B,
  parameter logic [7:0] T_PACK    = 8'h80,
  parameter logic [7:0] T_JAMCRC  = 8'hFF,
  parameter logic [7:0] T_EOP     = 8'h14,
  parameter logic [7:0] T_TXOFF   = 8'hFE,
  parameter logic [7:0] T_TXON    = 8'hA1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [2:0]            req_kind,
  input  logic [15:0]           req_header,
  input  logic [MAX_OBJ*32-1:0] req_objs,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [7:0]            out_data,
  output logic                  out_last,
  output logic                  fifo_flush,
  output logic                  hard_reset_cmd,
  output logic                  bist_mode,
  output logic                  tx_start,
  output logic                  req_error
);

  localparam int DATA_W = MAX_OBJ * 32;
  localparam int LEN_W  = $clog2(4 * (2 ** CNT_W) + 12);

  logic [LEN_W-1:0]  pay_len, frame_len, idx;
  logic              is_frame, is_hrst, is_bist, is_bad;
  logic [2:0]        kind_q;
  logic [15:0]       hdr_q;
  logic [DATA_W-1:0] objs_q;
  logic [LEN_W-1:0]  pay_q;
  logic              accept;

  assign accept = req_valid && req_ready;

  pd_tx_len_calc #(
    .MAX_OBJ(MAX_OBJ), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_len (
    .hdr(req_header), .kind(req_kind), .pay_len(pay_len), .frame_len(frame_len),
    .is_frame(is_frame), .is_hrst(is_hrst), .is_bist(is_bist), .is_bad(is_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      hdr_q  <= '0;
      objs_q <= '0;
      pay_q  <= '0;
    end else if (accept && is_frame) begin
      kind_q <= req_kind;
      hdr_q  <= req_header;
      objs_q <= req_objs;
      pay_q  <= pay_len;
    end
  end

  pd_tx_ctrl #(
    .LEN_W(LEN_W), .BIST_WAIT(BIST_WAIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .is_frame(is_frame), .is_hrst(is_hrst), .is_bad(is_bad || !(is_frame || is_hrst || is_bist)),
    .frame_len(frame_len), .out_ready(out_ready), .req_ready(req_ready), .idx(idx),
    .out_valid(out_valid), .out_last(out_last), .fifo_flush(fifo_flush),
    .hard_reset_cmd(hard_reset_cmd), .bist_mode(bist_mode), .tx_start(tx_start),
    .req_error(req_error)
  );

  pd_tx_byte_sel #(
    .MAX_OBJ(MAX_OBJ), .LEN_W(LEN_W),
    .T_SYNC1(T_SYNC1), .T_SYNC2(T_SYNC2), .T_SYNC3(T_SYNC3), .T_PACK(T_PACK),
    .T_JAMCRC(T_JAMCRC), .T_EOP(T_EOP), .T_TXOFF(T_TXOFF), .T_TXON(T_TXON)
  ) u_sel (
    .kind(kind_q), .hdr(hdr_q), .objs(objs_q), .pay_len(pay_q), .idx(idx), .byte_o(out_data)
  );

endmodule

// File: rtl/pd_tx_framer_chk.sv
module pd_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       fifo_flush,
  input logic       hard_reset_cmd,
  input logic       bist_mode,
  input logic       tx_start,
  input logic       req_error
);

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r6_busy_while_emit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  a_r6_last_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && req_ready);

  a_r5_flush_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> out_valid && !fifo_flush);

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_error |-> !out_valid && !fifo_flush);

  a_r8_hrst_single: assert property (@(posedge clk) disable iff (!rst_n)
    hard_reset_cmd |=> !hard_reset_cmd && req_ready);

  a_r9_start_inside_bist: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> bist_mode);

  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start && bist_mode);

  a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_flush, hard_reset_cmd, tx_start, req_error, out_valid}));

endmodule

bind pd_tx_framer pd_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .fifo_flush(fifo_flush), .hard_reset_cmd(hard_reset_cmd), .bist_mode(bist_mode),
  .tx_start(tx_start), .req_error(req_error)
);

// File: tb/pd_tx_framer_tb.sv
`timescale 1ns/100ps
module pd_tx_framer_tb;

  localparam int         MAX_OBJ = 7;
  localparam int         BWAIT   = 5;
  localparam logic [7:0] S1 = 8'h12, S2 = 8'h13, S3 = 8'h1B, PK = 8'h80;
  localparam logic [7:0] JC = 8'hFF, EP = 8'h14, TF = 8'hFE, TN = 8'hA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_kind = '0;
  logic [15:0] req_header = '0;
  logic [MAX_OBJ*32-1:0] req_objs = '0;
  logic out_valid, out_last, fifo_flush, hard_reset_cmd, bist_mode, tx_start, req_error;
  logic out_ready = 1'b0;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pd_tx_framer #(
    .MAX_OBJ(MAX_OBJ), .CNT_LSB(12), .CNT_W(4), .BIST_WAIT(BWAIT),
    .T_SYNC1(S1), .T_SYNC2(S2), .T_SYNC3(S3), .T_PACK(PK),
    .T_JAMCRC(JC), .T_EOP(EP), .T_TXOFF(TF), .T_TXON(TN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_header(req_header), .req_objs(req_objs),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .fifo_flush(fifo_flush), .hard_reset_cmd(hard_reset_cmd), .bist_mode(bist_mode),
    .tx_start(tx_start), .req_error(req_error)
  );

  // {kind, header}; the object count is header[15:12]
  localparam logic [18:0] VEC [6] = '{
    {3'd0, 16'h0041}, {3'd1, 16'h1161}, {3'd2, 16'h3A8F},
    {3'd0, 16'h7FFF}, {3'd1, 16'h2E44}, {3'd2, 16'h5123}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [MAX_OBJ*32-1:0] gen_objs(input int v);
    logic [MAX_OBJ*32-1:0] d;
    for (int w = 0; w < MAX_OBJ; w++)
      d[w*32 +: 32] = (32'h0403_0201 * (w + 1)) ^ {24'h5A5A00, 8'(v * 17 + w)};
    return d;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [2:0] k, input logic [15:0] h,
                                          input logic [MAX_OBJ*32-1:0] d, input int i);
    int n;
    n = 2 + 4 * int'(h[15:12]);
    if (i < 4) begin
      case (k)
        3'd0:    return (i == 3) ? S2 : S1;
        3'd1:    return (i < 2) ? S1 : S3;
        default: return (i % 2 == 0) ? S1 : S3;
      endcase
    end
    if (i == 4) return PK | 8'(n);
    if (i == 5) return h[7:0];
    if (i == 6) return h[15:8];
    if (i < 5 + n) return d[(i - 7) * 8 +: 8];
    case (i - 5 - n)
      0: return JC;
      1: return EP;
      2: return TF;
      default: return TN;
    endcase
  endfunction

  task automatic offer(input logic [2:0] k, input logic [15:0] h, input logic [MAX_OBJ*32-1:0] d);
    @(negedge clk);
    check(req_ready == 1'b1, "R6 ready before request", req_ready, 1);
    req_valid  = 1'b1;
    req_kind   = k;
    req_header = h;
    req_objs   = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_frame(input logic [2:0] k, input logic [15:0] h,
                           input logic [MAX_OBJ*32-1:0] d, input bit stall);
    int total, i, cyc;
    total = 9 + 2 + 4 * int'(h[15:12]);
    offer(k, h, d);
    check(fifo_flush == 1'b1 && out_valid == 1'b0, "R5 flush before data", fifo_flush, 1);
    check(req_ready == 1'b0, "R6 busy after accept", req_ready, 0);
    @(negedge clk);
    check(fifo_flush == 1'b0, "R5 flush single cycle", fifo_flush, 0);
    i = 0;
    cyc = 0;
    while (i < total && cyc < 400) begin
      out_ready = stall ? ((cyc % 3) != 2) : 1'b1;
      check(out_valid == 1'b1, "R6 valid during frame", out_valid, 1);
      if (i < 4)
        check(out_data == exp_byte(k, h, d, i), "R1 sync token", out_data, exp_byte(k, h, d, i));
      else if (i == 4)
        check(out_data == exp_byte(k, h, d, i), "R2 pack token", out_data, exp_byte(k, h, d, i));
      else if (i < total - 4)
        check(out_data == exp_byte(k, h, d, i), "R3 literal byte", out_data, exp_byte(k, h, d, i));
      else
        check(out_data == exp_byte(k, h, d, i), "R4 trailer token", out_data, exp_byte(k, h, d, i));
      check(out_last == (i == total - 1), "R4 last flag", out_last, (i == total - 1));
      if (out_ready) i++;
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0 && req_ready == 1'b1, "R6 idle after last", out_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, starts;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(req_ready == 1'b1, "R11 ready", req_ready, 1);
    check({out_valid, fifo_flush, hard_reset_cmd, bist_mode, tx_start, req_error} == 6'b0,
          "R11 outputs low", {out_valid, fifo_flush, hard_reset_cmd, bist_mode, tx_start, req_error}, 0);

    for (int v = 0; v < 6; v++)
      run_frame(VEC[v][18:16], VEC[v][15:0], gen_objs(v), v[0]);

    // R7 object count above MAX_OBJ
    offer(3'd0, 16'h8123, gen_objs(9));
    check(req_error == 1'b1, "R7 error pulse", req_error, 1);
    check(out_valid == 1'b0 && fifo_flush == 1'b0, "R7 nothing emitted", out_valid, 0);
    @(negedge clk);
    check(req_error == 1'b0 && req_ready == 1'b1 && out_valid == 1'b0, "R7 back to idle", req_error, 0);

    // R10 unsupported kind
    offer(3'd6, 16'h0000, gen_objs(1));
    check(req_error == 1'b1 && out_valid == 1'b0, "R10 error pulse", req_error, 1);
    @(negedge clk);
    check(req_error == 1'b0 && out_valid == 1'b0, "R10 quiet", req_error, 0);

    // R8 hard reset
    offer(3'd3, 16'h0000, gen_objs(2));
    check(hard_reset_cmd == 1'b1 && out_valid == 1'b0, "R8 hard reset pulse", hard_reset_cmd, 1);
    @(negedge clk);
    check(hard_reset_cmd == 1'b0 && req_ready == 1'b1, "R8 single cycle", hard_reset_cmd, 0);

    // R9 BIST burst
    offer(3'd4, 16'h0000, gen_objs(3));
    hi = 0;
    starts = 0;
    while (bist_mode && hi < 50) begin
      hi++;
      if (tx_start) starts++;
      if (hi == 1) check(tx_start == 1'b1, "R9 start in first cycle", tx_start, 1);
      check(req_ready == 1'b0 && out_valid == 1'b0, "R9 busy no data", req_ready, 0);
      @(negedge clk);
    end
    check(hi == 1 + BWAIT, "R9 bist length", hi, 1 + BWAIT);
    check(starts == 1, "R9 one start pulse", starts, 1);
    check(req_ready == 1'b1, "R9 idle after burst", req_ready, 1);

    // R6 frame after other paths, stalled
    run_frame(3'd0, 16'h0000, gen_objs(4), 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule